// File: doc/BRIEF.md
# Power Mode and Startup Sequencer

This block steps a lighting-driver chip through its power modes. After a reset it waits in a low-power standby mode until software sets a release bit. It then brings up the internal reference, bias and oscillator and holds them for an oscillator-settling delay. Next it either soft-starts the boost converter in pulse-frequency mode or goes straight to normal operation. The LED logic runs only in normal operation.

Both delays are counted in pulses of a 1 ms enable input, so the block never counts raw clocks. An over-temperature flag sends the machine back to internal startup and restarts the delay. In normal operation, software can turn the boost converter off and on again. Turning it back on repeats a settling wait and then the soft start before the converter moves to pulse-width operation.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `hw_rst_n` is low or `por_active` is high, `mode_state` reads 0 (reset) at once, regardless of the clock, and all four enable outputs are low. On the first clock after reset ends, `mode_state` becomes 1 (standby).
- R2: Outside reset, a low `stby_release` moves any state to standby (1) on the next clock. In standby all enables are low, and `therm_fault` has no effect there.
- R3: In standby with `stby_release` high, the next clock enters internal startup (2), where only `bias_en` is high. The machine stays there for exactly `STARTUP_TICKS` cycles in which `ms_tick` is high, however many clocks pass. On the clock of the last such tick it goes to soft start (3) if `boost_en` is 1, or to normal (4) otherwise.
- R4: A high `therm_fault` in internal startup, boost settle, soft start or normal enters internal startup (2) on the next clock. It stays there while the fault lasts. Each fault cycle discards any ticks already counted.
- R5: In soft start (3), `boost_run` is 1 and `boost_pwm` is 0 (pulse-frequency mode). After `SOFTSTART_TICKS` ticks it goes to normal (4), where `boost_pwm` reads 1.
- R6: `led_run` is 1 only in normal (4). In normal after a soft start, `boost_run` and `boost_pwm` follow `boost_en`. Clearing `boost_en` turns the converter off while the machine stays in normal.
- R7: In normal with the converter off, setting `boost_en` enters boost settle (5) on the next clock. There `bias_en` is 1 and the converter is off. After `STARTUP_TICKS` ticks it goes to soft start (3).
- R8: Clearing `boost_en` during boost settle (5) or soft start (3) returns the machine to normal (4) on the next clock with the converter off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Active-low reset pin, asynchronous |
| por_active | input | 1 | Power-on reset flag, active high, asynchronous |
| stby_release | input | 1 | Register bit; 1 leaves standby |
| boost_en | input | 1 | Register bit; 1 requests the boost converter |
| therm_fault | input | 1 | Over-temperature flag |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| bias_en | output | 1 | Enables reference, bias and oscillator |
| boost_run | output | 1 | Converter switching enabled |
| boost_pwm | output | 1 | 1 selects pulse-width mode, 0 pulse-frequency mode |
| led_run | output | 1 | LED logic may run |
| mode_state | output | 3 | Current state code (0..5 as in the requirements) |

## Verification
A wrong internal state reaches the ports with no delay, because `mode_state` and every enable are decoded directly from the state register. A wrong transition therefore shows up one clock after the stimulus that caused it. A delay counter that is off by one tick shifts the exit from startup, settle or soft start by exactly one tick pulse. To catch that, the bench places idle clocks between ticks and compares the state on every cycle. A converter flag that is not cleared after `boost_en` is withdrawn would show up as a wrong `boost_run` in normal operation. It would also send the machine to the wrong state when the converter is next enabled.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   localparam int unsigned STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      PS_RESET     = 3'd0,
      PS_STANDBY   = 3'd1,
      PS_INTSTART  = 3'd2,
      PS_SOFTSTART = 3'd3,
      PS_NORMAL    = 3'd4,
      PS_BSETTLE   = 3'd5
   } pwr_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
   parameter int unsigned STARTUP_TICKS   = 10,
   parameter int unsigned SOFTSTART_TICKS = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic tick,
   input  logic sel_soft,
   output logic done
);
   import pwrseq_pkg::*;

   localparam int unsigned MAX_T = (STARTUP_TICKS > SOFTSTART_TICKS) ? STARTUP_TICKS : SOFTSTART_TICKS;
   localparam int unsigned CW    = cnt_width(MAX_T);

   if (STARTUP_TICKS < 1) begin : g_chk_start
      $error("STARTUP_TICKS must be at least 1");
   end
   if (SOFTSTART_TICKS < 1) begin : g_chk_soft
      $error("SOFTSTART_TICKS must be at least 1");
   end

   if (MAX_T == 1) begin : g_single
      // every delay is one tick long: no counter needed
      logic unused_sig;
      assign unused_sig = ^{clk, rst, clr, sel_soft};
      assign done = tick;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] limit;

      assign limit = sel_soft ? CW'(SOFTSTART_TICKS - 1) : CW'(STARTUP_TICKS - 1);
      assign done  = tick && (cnt_q == limit);

      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            cnt_q <= '0;
         end else if (clr) begin
            cnt_q <= '0;
         end else if (tick && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   stby_release,
   input  logic                   boost_en,
   input  logic                   therm_fault,
   input  logic                   delay_done,
   output pwrseq_pkg::pwr_state_e state_q,
   output logic                   boost_live,
   output logic                   delay_clr,
   output logic                   delay_soft
);
   import pwrseq_pkg::*;

   pwr_state_e state_nx;

   always_comb begin
      state_nx = state_q;
      case (state_q)
         PS_RESET:    state_nx = PS_STANDBY;
         PS_STANDBY:  if (stby_release) state_nx = PS_INTSTART;
         PS_INTSTART: begin
            if (!therm_fault && delay_done)
               state_nx = boost_en ? PS_SOFTSTART : PS_NORMAL;
         end
         PS_BSETTLE: begin
            if (therm_fault)     state_nx = PS_INTSTART;
            else if (!boost_en)  state_nx = PS_NORMAL;
            else if (delay_done) state_nx = PS_SOFTSTART;
         end
         PS_SOFTSTART: begin
            if (therm_fault)     state_nx = PS_INTSTART;
            else if (!boost_en)  state_nx = PS_NORMAL;
            else if (delay_done) state_nx = PS_NORMAL;
         end
         PS_NORMAL: begin
            if (therm_fault)                 state_nx = PS_INTSTART;
            else if (boost_en && !boost_live) state_nx = PS_BSETTLE;
         end
         default: state_nx = PS_STANDBY;
      endcase
      if ((state_q != PS_RESET) && !stby_release) state_nx = PS_STANDBY;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q    <= PS_RESET;
         boost_live <= 1'b0;
      end else begin
         state_q <= state_nx;
         if ((state_q == PS_SOFTSTART) && (state_nx == PS_NORMAL) && boost_en)
            boost_live <= 1'b1;
         else if ((state_nx != PS_NORMAL) || !boost_en)
            boost_live <= 1'b0;
      end
   end

   // restart the delay on every state change and on each fault cycle
   assign delay_clr  = (state_nx != state_q) || therm_fault;
   assign delay_soft = (state_q == PS_SOFTSTART);

   assert_reset_hold_R1: assert property (@(posedge clk)
      rst |-> state_q == PS_RESET);

   assert_standby_entry_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q != PS_RESET && !stby_release) |=> state_q == PS_STANDBY);

   assert_release_start_R3: assert property (@(posedge clk) disable iff (rst)
      (state_q == PS_STANDBY && stby_release) |=> state_q == PS_INTSTART);

   assert_thermal_return_R4: assert property (@(posedge clk) disable iff (rst)
      (state_q != PS_RESET && state_q != PS_STANDBY && stby_release && therm_fault)
      |=> state_q == PS_INTSTART);

   assert_soft_to_normal_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == PS_SOFTSTART && stby_release && !therm_fault && boost_en && delay_done)
      |=> (state_q == PS_NORMAL && boost_live));

   assert_reenable_settle_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == PS_NORMAL && stby_release && !therm_fault && boost_en && !boost_live)
      |=> state_q == PS_BSETTLE);

   assert_abort_boost_R8: assert property (@(posedge clk) disable iff (rst)
      ((state_q == PS_BSETTLE || state_q == PS_SOFTSTART) && stby_release
       && !therm_fault && !boost_en) |=> (state_q == PS_NORMAL && !boost_live));

endmodule

// File: rtl/pwrseq_outputs.sv
module pwrseq_outputs (
   input  pwrseq_pkg::pwr_state_e state_q,
   input  logic                   boost_live,
   input  logic                   boost_en,
   output logic                   bias_en,
   output logic                   boost_run,
   output logic                   boost_pwm,
   output logic                   led_run
);
   import pwrseq_pkg::*;

   always_comb begin
      bias_en   = 1'b0;
      boost_run = 1'b0;
      boost_pwm = 1'b0;
      led_run   = 1'b0;
      case (state_q)
         PS_INTSTART, PS_BSETTLE: bias_en = 1'b1;
         PS_SOFTSTART: begin
            bias_en   = 1'b1;
            boost_run = 1'b1;
         end
         PS_NORMAL: begin
            bias_en   = 1'b1;
            led_run   = 1'b1;
            boost_run = boost_live && boost_en;
            boost_pwm = boost_live && boost_en;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
   parameter int unsigned STARTUP_TICKS   = 10,
   parameter int unsigned SOFTSTART_TICKS = 10
) (
   input  logic       clk,
   input  logic       hw_rst_n,
   input  logic       por_active,
   input  logic       stby_release,
   input  logic       boost_en,
   input  logic       therm_fault,
   input  logic       ms_tick,
   output logic       bias_en,
   output logic       boost_run,
   output logic       boost_pwm,
   output logic       led_run,
   output logic [2:0] mode_state
);
   import pwrseq_pkg::*;

   logic       rst_int;
   pwr_state_e state_q;
   logic       boost_live;
   logic       delay_clr;
   logic       delay_soft;
   logic       delay_done;

   assign rst_int = !hw_rst_n || por_active;

   pwrseq_delay #(
      .STARTUP_TICKS  (STARTUP_TICKS),
      .SOFTSTART_TICKS(SOFTSTART_TICKS)
   ) u_delay (
      .clk     (clk),
      .rst     (rst_int),
      .clr     (delay_clr),
      .tick    (ms_tick),
      .sel_soft(delay_soft),
      .done    (delay_done)
   );

   pwrseq_fsm u_fsm (
      .clk         (clk),
      .rst         (rst_int),
      .stby_release(stby_release),
      .boost_en    (boost_en),
      .therm_fault (therm_fault),
      .delay_done  (delay_done),
      .state_q     (state_q),
      .boost_live  (boost_live),
      .delay_clr   (delay_clr),
      .delay_soft  (delay_soft)
   );

   pwrseq_outputs u_out (
      .state_q   (state_q),
      .boost_live(boost_live),
      .boost_en  (boost_en),
      .bias_en   (bias_en),
      .boost_run (boost_run),
      .boost_pwm (boost_pwm),
      .led_run   (led_run)
   );

   assign mode_state = state_q;

endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
   localparam int CLK_PER = 10;
   localparam int ST = 4;
   localparam int SS = 3;

   localparam logic [2:0] S_RST = 3'd0, S_STBY = 3'd1, S_INT = 3'd2,
                          S_SOFT = 3'd3, S_NORM = 3'd4, S_SETL = 3'd5;

   logic clk = 1'b0;
   logic hw_rst_n, por_active, stby_release, boost_en, therm_fault, ms_tick;
   logic bias_en, boost_run, boost_pwm, led_run;
   logic [2:0] mode_state;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic [2:0] st;
      logic       bias;
      logic       brun;
      logic       bpwm;
      logic       led;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #(CLK_PER/2) clk = ~clk;

   pwr_mode_seq #(.STARTUP_TICKS(ST), .SOFTSTART_TICKS(SS)) u0 (
      .clk(clk), .hw_rst_n(hw_rst_n), .por_active(por_active),
      .stby_release(stby_release), .boost_en(boost_en),
      .therm_fault(therm_fault), .ms_tick(ms_tick),
      .bias_en(bias_en), .boost_run(boost_run), .boost_pwm(boost_pwm),
      .led_run(led_run), .mode_state(mode_state)
   );

   // expected enables per state, from the requirements
   function automatic exp_t make_exp(input logic [2:0] s, input logic ben);
      exp_t e;
      e.st = s; e.bias = 1'b0; e.brun = 1'b0; e.bpwm = 1'b0; e.led = 1'b0;
      case (s)
         S_INT, S_SETL: e.bias = 1'b1;
         S_SOFT: begin e.bias = 1'b1; e.brun = 1'b1; end
         S_NORM: begin e.bias = 1'b1; e.led = 1'b1; e.brun = ben; e.bpwm = ben; end
         default: ;
      endcase
      return e;
   endfunction

   // driver: inputs for the next edge are set, expectation queued
   task automatic go(input logic tk, input logic [2:0] s, input string tag);
      ms_tick = tk;
      exp_q.push_back(make_exp(s, boost_en));
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic cmp(input string tag, input string what, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // monitor: compares after every rising edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         cmp(t, "mode_state", mode_state, e.st);
         cmp(t, "bias_en",   {2'b0, bias_en},   {2'b0, e.bias});
         cmp(t, "boost_run", {2'b0, boost_run}, {2'b0, e.brun});
         cmp(t, "boost_pwm", {2'b0, boost_pwm}, {2'b0, e.bpwm});
         cmp(t, "led_run",   {2'b0, led_run},   {2'b0, e.led});
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      hw_rst_n = 1'b0; por_active = 1'b0; stby_release = 1'b0;
      boost_en = 1'b0; therm_fault = 1'b0; ms_tick = 1'b0;
      @(negedge clk);
      // R1: reset state, release ignored while in reset
      go(0, S_RST, "R1"); go(0, S_RST, "R1");
      stby_release = 1'b1;
      go(1, S_RST, "R1");
      hw_rst_n = 1'b1;
      go(0, S_STBY, "R1");
      // R3: startup counts ticks, not clocks
      go(0, S_INT, "R3");
      go(1, S_INT, "R3"); go(0, S_INT, "R3"); go(1, S_INT, "R3"); go(1, S_INT, "R3");
      go(1, S_NORM, "R3");
      go(1, S_NORM, "R6"); go(0, S_NORM, "R6");
      // R7 then R5: re-enable from normal
      boost_en = 1'b1;
      go(0, S_SETL, "R7");
      go(1, S_SETL, "R7"); go(1, S_SETL, "R7"); go(1, S_SETL, "R7");
      go(1, S_SOFT, "R7");
      go(1, S_SOFT, "R5"); go(0, S_SOFT, "R5"); go(1, S_SOFT, "R5");
      go(1, S_NORM, "R5");
      go(0, S_NORM, "R6");
      // R6: converter off, state stays normal
      boost_en = 1'b0;
      go(0, S_NORM, "R6"); go(1, S_NORM, "R6");
      // R8: withdraw during settle
      boost_en = 1'b1;
      go(0, S_SETL, "R7"); go(1, S_SETL, "R7");
      boost_en = 1'b0;
      go(0, S_NORM, "R8");
      // R8: withdraw during soft start
      boost_en = 1'b1;
      go(0, S_SETL, "R7");
      go(1, S_SETL, "R7"); go(1, S_SETL, "R7"); go(1, S_SETL, "R7");
      go(1, S_SOFT, "R7"); go(1, S_SOFT, "R5");
      boost_en = 1'b0;
      go(0, S_NORM, "R8");
      // R4: fault from settle, hold, partial count discarded
      boost_en = 1'b1;
      go(0, S_SETL, "R7");
      therm_fault = 1'b1;
      go(1, S_INT, "R4");
      go(1, S_INT, "R4"); go(1, S_INT, "R4"); go(1, S_INT, "R4"); go(1, S_INT, "R4");
      therm_fault = 1'b0;
      go(1, S_INT, "R4"); go(1, S_INT, "R4");
      therm_fault = 1'b1;
      go(0, S_INT, "R4");
      therm_fault = 1'b0;
      go(1, S_INT, "R4"); go(1, S_INT, "R4"); go(1, S_INT, "R4");
      go(1, S_SOFT, "R4");
      go(1, S_SOFT, "R5"); go(1, S_SOFT, "R5");
      go(1, S_NORM, "R5");
      // R4: fault from normal, then start without converter
      therm_fault = 1'b1;
      go(0, S_INT, "R4");
      therm_fault = 1'b0; boost_en = 1'b0;
      go(1, S_INT, "R4"); go(1, S_INT, "R4"); go(1, S_INT, "R4");
      go(1, S_NORM, "R3");
      // R2: standby entry, fault ignored there
      stby_release = 1'b0;
      go(0, S_STBY, "R2");
      therm_fault = 1'b1;
      go(1, S_STBY, "R2");
      therm_fault = 1'b0;
      go(1, S_STBY, "R2");
      // R2: standby from soft start
      stby_release = 1'b1; boost_en = 1'b1;
      go(0, S_INT, "R3");
      go(1, S_INT, "R3"); go(1, S_INT, "R3"); go(1, S_INT, "R3");
      go(1, S_SOFT, "R3");
      stby_release = 1'b0;
      go(0, S_STBY, "R2");
      // R1: power-on reset mid-startup
      stby_release = 1'b1;
      go(0, S_INT, "R3"); go(1, S_INT, "R3");
      por_active = 1'b1;
      go(0, S_RST, "R1");
      por_active = 1'b0;
      go(0, S_STBY, "R1");
      go(0, S_INT, "R3");
      @(negedge clk);
      finish_run();
   end

endmodule